// File: doc/BRIEF.md
# Flash Write Pulse Timing Monitor

This block watches the two active-low strobes, chip enable and write enable, that a controller drives toward a parallel NOR flash, both already sampled into the monitor's clock domain. A flash accepts a write only while both strobes are low. So the monitor treats the overlap of the two as the real write pulse, whichever strobe is the one that moves. It counts how many cycles each overlap lasts and how many cycles pass between the end of one overlap and the start of the next. It compares both numbers against minimum widths that are held per memory region.

The same write enable may stay low across many writes while chip enable alone toggles. The monitor then still sees separate pulses, each with its own gap. Every finished pulse produces a one-cycle commit strobe. A width below its limit sets a sticky violation flag that stays set until it is cleared. The most recent pulse width and gap width remain visible on the outputs. A system integrator places the monitor beside the flash interface to catch timing settings that are too aggressive.

Top module: `fwm_monitor`

## Requirements
- R1: The effective pulse is active in every cycle where `enable` is high and both `ce_n` and `we_n` sample low. In the cycle after the first sample in which the pulse is inactive again, `write_commit` is high for exactly one cycle, and `last_low_width` holds the number of cycles the pulse was active.
- R2: A pulse ends on whichever strobe rises first. If `we_n` stays low while `ce_n` toggles, each low period of `ce_n` is a separate pulse with its own commit.
- R3: The gap width is the number of inactive cycles from the end of one pulse to the start of the next. It appears on `last_high_width` one cycle after the first active cycle of the new pulse.
- R4: If a pulse's width is below `min_low` of the selected region, `low_width_viol` rises together with that pulse's commit and stays high.
- R5: If a gap is below `min_high` of the selected region, `high_width_viol` rises one cycle after the new pulse starts. The first pulse after reset, and the first pulse after `enable` goes high, is not checked for its gap and does not update `last_high_width`.
- R6: Each of the REGIONS regions (default 4) has its own pair of minimums. A cycle with `cfg_load` high writes `cfg_min_low` and `cfg_min_high` into region `cfg_region`. After reset every minimum is 255.
- R7: The width counters are 8 bits wide and saturate at 255, so longer pulses and gaps are reported as 255.
- R8: A cycle with `clear` high resets both violation flags, unless a violation is detected in that same cycle, in which case the flag is set.
- R9: While `enable` is low there are no commits, the flags and widths hold their values, and a pulse that is cut short by `enable` falling is dropped without a commit.
- R10: `region_sel` chooses which region's minimums apply at the moment a pulse or gap is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Monitoring enable |
| clear | input | 1 | Clears the sticky violation flags |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| cfg_load | input | 1 | Writes one region's minimums |
| cfg_region | input | 2 | Region written by cfg_load |
| cfg_min_low | input | 8 | Minimum pulse width to write |
| cfg_min_high | input | 8 | Minimum gap width to write |
| region_sel | input | 2 | Region whose minimums apply |
| write_commit | output | 1 | One-cycle strobe per completed pulse |
| low_width_viol | output | 1 | Sticky: a pulse was too short |
| high_width_viol | output | 1 | Sticky: a gap was too short |
| last_low_width | output | 8 | Width of the last pulse, in cycles |
| last_high_width | output | 8 | Width of the last checked gap, in cycles |

## Verification
Two cases are hard to reach from the ports. The first is the run of back-to-back pulses with `we_n` held low the whole time. The stimulus gets there by toggling only `ce_n` around a constant low write enable, and it checks each gap, including a one-cycle gap, on the next pulse's first cycle. The second is the interaction of `enable` with the gap check and with pulses cut short. Here the bench drops `enable` in the middle of a pulse, raises it again, and starts a new pulse after a gap far below the limit, which must leave the gap flag and the reported gap untouched. The bench also lines up `clear` with the exact edge at which a violation is detected, to show that the set takes priority.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    parameter int unsigned CNT_W   = 8;
    parameter int unsigned REGIONS = 4;

    localparam int unsigned REG_W = (REGIONS > 1) ? $clog2(REGIONS) : 1;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        cnt_t min_low;
        cnt_t min_high;
    } limits_t;

    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_START = 2'd1,
        EDGE_END   = 2'd2
    } edge_e;

    function automatic cnt_t sat_inc(cnt_t v);
        return (v == CNT_MAX) ? v : v + cnt_t'(1);
    endfunction

    function automatic logic below(cnt_t width, cnt_t limit);
        return width < limit;
    endfunction

endpackage

// File: rtl/fwm_strobe_combiner.sv
module fwm_strobe_combiner
    import fwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  ce_n,
    input  logic  we_n,
    output logic  active,
    output edge_e edge_ev
);

    logic active_q;

    assign active = enable & ~ce_n & ~we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active;
        end
    end

    always_comb begin
        edge_ev = EDGE_NONE;
        if (active && !active_q) begin
            edge_ev = EDGE_START;
        end else if (enable && !active && active_q) begin
            edge_ev = EDGE_END;
        end
    end

    // R2
    end_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_ev == EDGE_END) |-> ((ce_n || we_n) && $past(active)));

endmodule

// File: rtl/fwm_width_counter.sv
module fwm_width_counter
    import fwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic restart,
    input  logic run,
    output cnt_t count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (restart) begin
            count <= cnt_t'(1);
        end else if (run) begin
            count <= sat_inc(count);
        end
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && run && !restart && !clr) |=> (count == CNT_MAX));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart && !clr) |=> $stable(count));

endmodule

// File: rtl/fwm_limit_bank.sv
module fwm_limit_bank
    import fwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [REG_W-1:0] cfg_region,
    input  cnt_t             cfg_min_low,
    input  cnt_t             cfg_min_high,
    input  logic [REG_W-1:0] sel,
    output limits_t          lim
);

    limits_t bank [REGIONS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < REGIONS; r++) begin
            if (rst) begin
                bank[r] <= '{min_low: CNT_MAX, min_high: CNT_MAX};
            end else if (cfg_load && cfg_region == REG_W'(r)) begin
                bank[r] <= '{min_low: cfg_min_low, min_high: cfg_min_high};
            end
        end
    end

    assign lim = bank[sel];

    for (genvar r = 0; r < REGIONS; r++) begin : g_chk
        // R6
        region_write_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_load && cfg_region == REG_W'(r)) |=>
                (bank[r].min_low == $past(cfg_min_low) &&
                 bank[r].min_high == $past(cfg_min_high)));
    end

endmodule

// File: rtl/fwm_judge.sv
module fwm_judge
    import fwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    clear,
    input  edge_e   edge_ev,
    input  cnt_t    low_w,
    input  cnt_t    high_w,
    input  limits_t lim,
    output logic    commit,
    output cnt_t    last_low,
    output cnt_t    last_high,
    output logic    low_viol,
    output logic    high_viol
);

    logic have_prev;
    logic low_set;
    logic high_set;

    assign low_set  = (edge_ev == EDGE_END) && below(low_w, lim.min_low);
    assign high_set = (edge_ev == EDGE_START) && have_prev && below(high_w, lim.min_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            commit    <= 1'b0;
            last_low  <= '0;
            last_high <= '0;
            low_viol  <= 1'b0;
            high_viol <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            commit <= (edge_ev == EDGE_END);
            if (edge_ev == EDGE_END) begin
                last_low <= low_w;
            end
            if (edge_ev == EDGE_START && have_prev) begin
                last_high <= high_w;
            end
            if (!enable) begin
                have_prev <= 1'b0;
            end else if (edge_ev == EDGE_END) begin
                have_prev <= 1'b1;
            end
            low_viol  <= low_set  | (low_viol  & ~clear);
            high_viol <= high_set | (high_viol & ~clear);
        end
    end

    // R1
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R4
    low_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (low_viol && !clear) |=> low_viol);

    // R5
    high_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(high_viol) |-> $past(edge_ev == EDGE_START));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !commit);

endmodule

// File: rtl/fwm_monitor.sv
module fwm_monitor
    import fwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clear,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cfg_load,
    input  logic [REG_W-1:0] cfg_region,
    input  logic [CNT_W-1:0] cfg_min_low,
    input  logic [CNT_W-1:0] cfg_min_high,
    input  logic [REG_W-1:0] region_sel,
    output logic             write_commit,
    output logic             low_width_viol,
    output logic             high_width_viol,
    output logic [CNT_W-1:0] last_low_width,
    output logic [CNT_W-1:0] last_high_width
);

    logic    active;
    edge_e   edge_ev;
    limits_t lim;
    logic    restart_v [2];
    logic    run_v     [2];
    cnt_t    width_v   [2];

    fwm_strobe_combiner u_comb (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .active  (active),
        .edge_ev (edge_ev)
    );

    // index 0 counts the pulse, index 1 counts the gap
    assign restart_v[0] = (edge_ev == EDGE_START);
    assign restart_v[1] = (edge_ev == EDGE_END);
    assign run_v[0]     = active;
    assign run_v[1]     = ~active;

    for (genvar p = 0; p < 2; p++) begin : g_phase
        fwm_width_counter u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clr     (~enable),
            .restart (restart_v[p]),
            .run     (run_v[p]),
            .count   (width_v[p])
        );
    end

    fwm_limit_bank u_bank (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_region   (cfg_region),
        .cfg_min_low  (cfg_min_low),
        .cfg_min_high (cfg_min_high),
        .sel          (region_sel),
        .lim          (lim)
    );

    fwm_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .clear     (clear),
        .edge_ev   (edge_ev),
        .low_w     (width_v[0]),
        .high_w    (width_v[1]),
        .lim       (lim),
        .commit    (write_commit),
        .last_low  (last_low_width),
        .last_high (last_high_width),
        .low_viol  (low_width_viol),
        .high_viol (high_width_viol)
    );

endmodule

// File: tb/fwm_monitor_tb.sv
module fwm_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       clear = 1'b0;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_region = '0;
    logic [7:0] cfg_min_low = '0;
    logic [7:0] cfg_min_high = '0;
    logic [1:0] region_sel = '0;
    logic       write_commit;
    logic       low_width_viol;
    logic       high_width_viol;
    logic [7:0] last_low_width;
    logic [7:0] last_high_width;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fwm_monitor dut_i (
        .clk             (clk),
        .rst             (rst),
        .enable          (enable),
        .clear           (clear),
        .ce_n            (ce_n),
        .we_n            (we_n),
        .cfg_load        (cfg_load),
        .cfg_region      (cfg_region),
        .cfg_min_low     (cfg_min_low),
        .cfg_min_high    (cfg_min_high),
        .region_sel      (region_sel),
        .write_commit    (write_commit),
        .low_width_viol  (low_width_viol),
        .high_width_viol (high_width_viol),
        .last_low_width  (last_low_width),
        .last_high_width (last_high_width)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge after n rising edges
    task automatic drive(input logic ce, input logic we, input int n);
        ce_n = ce;
        we_n = we;
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int r, input int lo, input int hi);
        cfg_region   = 2'(r);
        cfg_min_low  = 8'(lo);
        cfg_min_high = 8'(hi);
        cfg_load     = 1'b1;
        @(negedge clk);
        cfg_load     = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset commit", int'(write_commit), 0);
        check("R4 reset low flag", int'(low_width_viol), 0);
        check("R5 reset high flag", int'(high_width_viol), 0);
        check("R1 reset low width", int'(last_low_width), 0);
    endtask

    task automatic t_defaults();
        drive(1, 1, 2);
        drive(0, 0, 3);
        drive(1, 1, 1);
        check("R6 default min_low flags 3-cycle pulse", int'(low_width_viol), 1);
        check("R5 first pulse gap not checked", int'(high_width_viol), 0);
        drive(1, 1, 3);
        drive(0, 0, 1);
        check("R6 default min_high flags 4-cycle gap", int'(high_width_viol), 1);
        check("R3 gap width", int'(last_high_width), 4);
        drive(0, 0, 1);
        drive(1, 1, 3);
    endtask

    task automatic t_clear();
        do_clear();
        check("R8 clear low flag", int'(low_width_viol), 0);
        check("R8 clear high flag", int'(high_width_viol), 0);
    endtask

    task automatic t_we_controlled();
        cfg(0, 3, 2);
        region_sel = 2'd0;
        drive(0, 1, 2);
        drive(0, 0, 5);
        drive(0, 1, 1);
        check("R1 commit after write-enable release", int'(write_commit), 1);
        check("R1 pulse width 5", int'(last_low_width), 5);
        check("R4 5 >= 3 no low flag", int'(low_width_viol), 0);
        drive(0, 1, 1);
        check("R1 commit lasts one cycle", int'(write_commit), 0);
        drive(1, 1, 2);
        drive(0, 0, 1);
        check("R3 gap width 4", int'(last_high_width), 4);
        check("R5 4 >= 2 no high flag", int'(high_width_viol), 0);
        drive(0, 0, 1);
        drive(1, 0, 1);
        check("R2 commit on chip-enable release", int'(write_commit), 1);
        check("R2 pulse width 2", int'(last_low_width), 2);
        check("R4 2 < 3 sets low flag", int'(low_width_viol), 1);
        drive(1, 1, 2);
    endtask

    task automatic t_back_to_back();
        do_clear();
        cfg(0, 2, 3);
        drive(1, 0, 3);
        drive(0, 0, 3);
        drive(1, 0, 1);
        check("R2 pulse A commit with write enable held", int'(write_commit), 1);
        check("R2 pulse A width", int'(last_low_width), 3);
        check("R5 no high flag before short gap", int'(high_width_viol), 0);
        drive(0, 0, 1);
        check("R3 one-cycle gap", int'(last_high_width), 1);
        check("R5 1 < 3 sets high flag", int'(high_width_viol), 1);
        drive(0, 0, 2);
        drive(1, 0, 1);
        check("R2 pulse B commit", int'(write_commit), 1);
        drive(1, 0, 2);
        drive(0, 0, 1);
        check("R3 three-cycle gap", int'(last_high_width), 3);
        drive(0, 0, 2);
        drive(1, 0, 1);
        check("R2 pulse C commit", int'(write_commit), 1);
        check("R4 3 >= 2 no low flag", int'(low_width_viol), 0);
        drive(1, 1, 2);
    endtask

    task automatic t_set_wins();
        do_clear();
        cfg(0, 4, 0);
        drive(0, 0, 2);
        clear = 1'b1;
        drive(1, 1, 1);
        clear = 1'b0;
        check("R8 set beats clear in same cycle", int'(low_width_viol), 1);
        do_clear();
        check("R8 later clear", int'(low_width_viol), 0);
        drive(1, 1, 2);
    endtask

    task automatic t_region();
        cfg(1, 5, 0);
        cfg(0, 1, 0);
        region_sel = 2'd1;
        drive(0, 0, 3);
        drive(1, 1, 1);
        check("R10 region 1 limit applies", int'(low_width_viol), 1);
        drive(1, 1, 1);
        do_clear();
        region_sel = 2'd0;
        drive(0, 0, 3);
        drive(1, 1, 1);
        check("R10 region 0 limit applies", int'(low_width_viol), 0);
        drive(1, 1, 2);
    endtask

    task automatic t_enable();
        int gap_before;
        cfg(0, 3, 10);
        do_clear();
        drive(1, 1, 12);
        drive(0, 0, 2);
        drive(1, 1, 1);
        check("R4 low flag before disable", int'(low_width_viol), 1);
        check("R1 width before disable", int'(last_low_width), 2);
        gap_before = int'(last_high_width);
        enable = 1'b0;
        drive(0, 0, 4);
        drive(1, 1, 1);
        check("R9 no commit while disabled", int'(write_commit), 0);
        check("R9 width held while disabled", int'(last_low_width), 2);
        check("R9 flag held while disabled", int'(low_width_viol), 1);
        enable = 1'b1;
        drive(1, 1, 1);
        drive(0, 0, 2);
        check("R5 first pulse after enable not gap-checked", int'(high_width_viol), 0);
        check("R5 gap width not updated after enable", int'(last_high_width), gap_before);
        enable = 1'b0;
        drive(1, 1, 1);
        check("R9 pulse cut by disable has no commit", int'(write_commit), 0);
        enable = 1'b1;
        drive(1, 1, 2);
    endtask

    task automatic t_saturate();
        do_clear();
        cfg(0, 0, 0);
        drive(1, 1, 2);
        drive(0, 0, 300);
        drive(1, 1, 1);
        check("R7 pulse width saturates", int'(last_low_width), 255);
        drive(1, 1, 299);
        drive(0, 0, 1);
        check("R7 gap width saturates", int'(last_high_width), 255);
        drive(1, 1, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_clear();
        t_we_controlled();
        t_back_to_back();
        t_set_wins();
        t_region();
        t_enable();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule